// File: doc/BRIEF.md
# Register Read-After-Write Bypass and Load-Use Interlock

This block is the register hazard controller for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). It takes the instruction word sitting in decode each cycle and decodes which register fields that instruction reads and which one it writes. The decoding depends on the instruction class. It carries that usage information down a private shadow of the execute, memory and writeback pipeline registers. From that shadow it produces two things for the datapath. The first is a 2-bit operand-select per ALU source, which picks either the value read from the register file or a result that is already computed further down the pipe. The second is a stall request for the one case that cannot be bypassed: a load whose result is wanted by the instruction right behind it.

The datapath uses the selects to steer its execute-stage operand multiplexers. It uses the stall to hold the program counter and the fetch/decode register for one cycle, while this block places an empty slot into execute. Only register indices are compared. Memory addresses, immediate offsets and memory contents never take part. A producer three instructions ahead is not handled here at all, because the register file writes first and reads second within a cycle.

Top module: `raw_bypass_ctrl`

## Requirements
- R1: The instruction word is decoded as follows: opcode in bits 31:26, first source index in bits 25:21, second source index in bits 20:16, and result index in bits 15:11. Opcode 0x00 reads both sources and writes the bits 15:11 register. Opcodes 0x08 to 0x0F read the first source and write the bits 20:16 register. Opcode 0x23 (load) reads the first source and writes the bits 20:16 register. Opcode 0x2B (store) reads both sources and writes nothing. Every other opcode reads and writes nothing.
- R2: `fwd_a_sel` steers the first-source operand and `fwd_b_sel` steers the second-source operand. The encoding is 00 = register file, 10 = execute/memory result, 01 = memory/writeback result. A select is 00 whenever the instruction in execute does not read that source.
- R3: When the producer is one instruction ahead of the consumer and is not a load, the matching select of the consumer in execute is 10.
- R4: When the producer is two instructions ahead, the matching select is 01.
- R5: When the producer is three instructions ahead, the select is 00.
- R6: When both the execute/memory and the memory/writeback instructions write the consumed register, the select is 10.
- R7: A result index of 0 never causes a forward or a stall.
- R8: A store never acts as a producer. Consumers of its second-source register get select 00 and no stall.
- R9: When a load is in execute and the instruction in decode reads the load's target, `stall` is high in that same cycle. In the next cycle, execute holds an empty slot (`ex_bubble` = 1, both selects 00) and `stall` is low. When the held consumer then enters execute, its matching select is 01.
- R10: Hazards depend only on register indices. The 16-bit immediate and the memory address have no effect on any output.
- R11: While reset is applied, all three shadow stages are empty: `ex_bubble` = 1, both selects are 00, and `stall` is 0 for an instruction that reads nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_instr | input | 32 | Instruction word currently in decode |
| stall | output | 1 | Hold PC and fetch/decode register; bubble goes to execute |
| fwd_a_sel | output | 2 | Operand select for first source of the execute instruction |
| fwd_b_sel | output | 2 | Operand select for second source of the execute instruction |
| ex_bubble | output | 1 | Execute stage holds an empty slot |

## Verification
The assertions cover the following on every cycle:
- A stall is always followed by exactly one empty execute slot and is never repeated for the same load.
- A load sitting in execute/memory is never chosen as a bypass source.
- An empty slot never requests a bypass.
- A stall never names register 0, and a store never claims a result register.

Only the bench scenarios can show that each select value appears at the right distance between producer and consumer, that class-dependent source usage suppresses bypasses for unread operands, that the priority between the two bypass sources is correct, and that the immediate field plays no part. The bench sweeps every pairing of producer class, consumer class, distance, matched operand and result index.

// File: rtl/raw_pkg.sv
package raw_pkg;

  localparam int unsigned INSTR_W = 32;
  localparam int unsigned RIDX_W  = 5;
  localparam int unsigned OPC_W   = 6;
  localparam int unsigned NUM_SRC = 2;
  localparam int unsigned SHADOW_DEPTH = 3;

  // source slot positions
  localparam int unsigned SRC_RS = 0;
  localparam int unsigned SRC_RT = 1;

  // shadow stage positions
  localparam int unsigned STG_EX  = 0;
  localparam int unsigned STG_MEM = 1;
  localparam int unsigned STG_WB  = 2;

  // instruction field positions
  localparam int unsigned OPC_LSB = INSTR_W - OPC_W;
  localparam int unsigned RS_LSB  = OPC_LSB - RIDX_W;
  localparam int unsigned RT_LSB  = RS_LSB - RIDX_W;
  localparam int unsigned RD_LSB  = RT_LSB - RIDX_W;

  localparam logic [OPC_W-1:0] OPC_REG   = 6'h00;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;
  localparam logic [2:0]       OPC_IMM_TAG = 3'b001;

  typedef logic [RIDX_W-1:0] ridx_t;

  typedef struct packed {
    logic                   vld;
    logic                   is_load;
    logic                   wr;
    ridx_t                  wdst;
    logic [NUM_SRC-1:0]     rd_use;
    ridx_t [NUM_SRC-1:0]    src;
  } use_t;

  typedef enum logic [1:0] {
    SEL_RF    = 2'b00,
    SEL_MEMWB = 2'b01,
    SEL_EXMEM = 2'b10
  } fwd_sel_e;

endpackage

// File: rtl/raw_decode.sv
module raw_decode
  import raw_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output use_t               use_o
);

  logic [OPC_W-1:0] opc;
  ridx_t            f_rs;
  ridx_t            f_rt;
  ridx_t            f_rd;
  logic             unused_low;

  assign opc  = instr_i[OPC_LSB +: OPC_W];
  assign f_rs = instr_i[RS_LSB +: RIDX_W];
  assign f_rt = instr_i[RT_LSB +: RIDX_W];
  assign f_rd = instr_i[RD_LSB +: RIDX_W];
  assign unused_low = ^instr_i[RD_LSB-1:0];

  always_comb begin
    use_o             = '0;
    use_o.vld         = 1'b1;
    use_o.src[SRC_RS] = f_rs;
    use_o.src[SRC_RT] = f_rt;
    if (opc == OPC_REG) begin
      use_o.rd_use = '1;
      use_o.wr     = 1'b1;
      use_o.wdst   = f_rd;
    end else if (opc[OPC_W-1 -: 3] == OPC_IMM_TAG) begin
      use_o.rd_use[SRC_RS] = 1'b1;
      use_o.wr             = 1'b1;
      use_o.wdst           = f_rt;
    end else if (opc == OPC_LOAD) begin
      use_o.rd_use[SRC_RS] = 1'b1;
      use_o.wr             = 1'b1;
      use_o.wdst           = f_rt;
      use_o.is_load        = 1'b1;
    end else if (opc == OPC_STORE) begin
      use_o.rd_use = '1;
    end
    // register 0 is hardwired: never a real result
    if (use_o.wdst == '0) begin
      use_o.wr = 1'b0;
    end
  end

endmodule

// File: rtl/raw_stage_pipe.sv
module raw_stage_pipe
  import raw_pkg::*;
#(
  parameter int unsigned DEPTH = SHADOW_DEPTH
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bubble_i,
  input  use_t                 use_i,
  output use_t [DEPTH-1:0]     stg_o
);

  use_t [DEPTH-1:0] stg_d;
  use_t [DEPTH-1:0] stg_q;

  // next state: entry takes decode usage or an empty slot, rest shift
  always_comb begin
    stg_d[0] = bubble_i ? use_t'('0) : use_i;
    for (int i = 1; i < int'(DEPTH); i++) begin
      stg_d[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_d;
    end
  end

  assign stg_o = stg_q;

endmodule

// File: rtl/raw_lu_detect.sv
module raw_lu_detect
  import raw_pkg::*;
(
  input  use_t id_use_i,
  input  use_t ex_use_i,
  output logic stall_o
);

  logic [NUM_SRC-1:0] hit;
  logic               ld_live;
  logic               unused_fields;

  assign ld_live = ex_use_i.vld && ex_use_i.is_load && ex_use_i.wr;

  always_comb begin
    for (int s = 0; s < int'(NUM_SRC); s++) begin
      hit[s] = id_use_i.rd_use[s] && (id_use_i.src[s] == ex_use_i.wdst);
    end
  end

  assign stall_o = ld_live && id_use_i.vld && (|hit);

  assign unused_fields = ^{id_use_i.is_load, id_use_i.wr, id_use_i.wdst,
                           ex_use_i.rd_use, ex_use_i.src};

endmodule

// File: rtl/raw_fwd_pick.sv
module raw_fwd_pick
  import raw_pkg::*;
(
  input  logic     rd_use_i,
  input  ridx_t    src_i,
  input  use_t     exmem_i,
  input  use_t     memwb_i,
  output fwd_sel_e sel_o
);

  logic near_hit;
  logic far_hit;
  logic unused_fields;

  assign near_hit = exmem_i.vld && exmem_i.wr && (exmem_i.wdst == src_i);
  assign far_hit  = memwb_i.vld && memwb_i.wr && (memwb_i.wdst == src_i);

  // nearest producer wins
  always_comb begin
    sel_o = SEL_RF;
    if (rd_use_i) begin
      if (near_hit) begin
        sel_o = SEL_EXMEM;
      end else if (far_hit) begin
        sel_o = SEL_MEMWB;
      end
    end
  end

  assign unused_fields = ^{exmem_i.rd_use, exmem_i.src, exmem_i.is_load,
                           memwb_i.rd_use, memwb_i.src, memwb_i.is_load};

endmodule

// File: rtl/raw_bypass_ctrl.sv
module raw_bypass_ctrl
  import raw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] id_instr,
  output logic               stall,
  output logic [1:0]         fwd_a_sel,
  output logic [1:0]         fwd_b_sel,
  output logic               ex_bubble
);

  use_t                    id_use;
  use_t [SHADOW_DEPTH-1:0] stg;
  fwd_sel_e                sel [NUM_SRC];

  raw_decode u_decode (
    .instr_i (id_instr),
    .use_o   (id_use)
  );

  raw_lu_detect u_lu (
    .id_use_i (id_use),
    .ex_use_i (stg[STG_EX]),
    .stall_o  (stall)
  );

  raw_stage_pipe #(.DEPTH(SHADOW_DEPTH)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .bubble_i (stall),
    .use_i    (id_use),
    .stg_o    (stg)
  );

  for (genvar g = 0; g < int'(NUM_SRC); g++) begin : g_src
    raw_fwd_pick u_pick (
      .rd_use_i (stg[STG_EX].vld && stg[STG_EX].rd_use[g]),
      .src_i    (stg[STG_EX].src[g]),
      .exmem_i  (stg[STG_MEM]),
      .memwb_i  (stg[STG_WB]),
      .sel_o    (sel[g])
    );
  end

  assign fwd_a_sel = sel[SRC_RS];
  assign fwd_b_sel = sel[SRC_RT];
  assign ex_bubble = !stg[STG_EX].vld;

  // R9
  stall_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ex_bubble);

  // R9
  stall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  // R9
  ld_exmem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a_sel == SEL_EXMEM || fwd_b_sel == SEL_EXMEM) |-> !stg[STG_MEM].is_load);

  // R11
  bubble_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ex_bubble |-> (fwd_a_sel == SEL_RF && fwd_b_sel == SEL_RF));

  // R7
  r0_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (stg[STG_EX].wdst != '0));

  // R8
  store_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_instr[OPC_LSB +: OPC_W] == OPC_STORE) |-> !id_use.wr);

endmodule

// File: tb/raw_bypass_ctrl_bench.sv
module raw_bypass_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] id_instr;
  logic        stall;
  logic [1:0]  fwd_a_sel;
  logic [1:0]  fwd_b_sel;
  logic        ex_bubble;

  int n_chk = 0;
  int n_err = 0;

  logic [1:0] cap_a;
  logic [1:0] cap_b;
  logic       cap_bub;
  logic       cap_stall;

  localparam logic [31:0] NOP = {6'h3F, 26'h0};

  always #4 clk = ~clk;

  raw_bypass_ctrl u_raw_bypass_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .id_instr  (id_instr),
    .stall     (stall),
    .fwd_a_sel (fwd_a_sel),
    .fwd_b_sel (fwd_b_sel),
    .ex_bubble (ex_bubble)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // capture execute-stage view, then present a new decode instruction
  task automatic step(input logic [31:0] ins);
    @(negedge clk);
    cap_a   = fwd_a_sel;
    cap_b   = fwd_b_sel;
    cap_bub = ex_bubble;
    id_instr = ins;
    #1;
    cap_stall = stall;
  endtask

  // class: 0 register ALU, 1 immediate ALU, 2 load, 3 store (R1 encodings)
  function automatic logic [31:0] build(input int cls, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [4:0] rd,
                                        input logic [15:0] imm);
    case (cls)
      0:       return {6'h00, rs, rt, rd, 11'd0};
      1:       return {6'h0A, rs, rt, imm};
      2:       return {6'h23, rs, rt, imm};
      default: return {6'h2B, rs, rt, imm};
    endcase
  endfunction

  function automatic string tagof(input int p, input int gap, input int d, input bit ld);
    if (d == 0) return "R7";
    if (p == 3) return "R8";
    if (ld)     return "R9";
    if (gap == 1) return "R3";
    if (gap == 2) return "R4";
    return "R5";
  endfunction

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int dsel [3] = '{0, 7, 31};
    rst_n    = 1'b0;
    id_instr = NOP;
    #20;
    // R11 reset state
    chk("R11 ex_bubble", int'(ex_bubble), 1);
    chk("R11 fwd_a_sel", int'(fwd_a_sel), 0);
    chk("R11 fwd_b_sel", int'(fwd_b_sel), 0);
    chk("R11 stall", int'(stall), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R10 sweep: every class pair, distance, matched operand, index; imm varies
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 4; c++) begin
        for (int gap = 1; gap <= 3; gap++) begin
          for (int m = 0; m < 3; m++) begin
            for (int di = 0; di < 3; di++) begin
              int d = dsel[di];
              logic [15:0] imm = 16'((d * 37 + gap * 1000 + m * 7919 + p * 13 + c) & 16'hFFFF);
              bit pw, rdb, ma, mb, ld;
              int sel_hit, ea, eb;
              string tg, tgb;
              logic [31:0] prod, cons;
              if (m == 2) imm = imm | 16'h8000;
              pw  = (p != 3) && (d != 0);
              rdb = (c == 0) || (c == 3);
              ma  = (m != 1);
              mb  = rdb && (m != 0);
              ld  = pw && (p == 2) && (gap == 1) && (ma || mb);
              sel_hit = (gap == 1) ? (ld ? 1 : 2) : ((gap == 2) ? 1 : 0);
              ea = (pw && ma) ? sel_hit : 0;
              eb = (pw && mb) ? sel_hit : 0;
              tg  = $sformatf("%s/R1/R10 p%0d c%0d g%0d m%0d d%0d", tagof(p, gap, d, ld), p, c, gap, m, d);
              tgb = rdb ? tg : $sformatf("R2 p%0d c%0d g%0d m%0d d%0d", p, c, gap, m, d);
              prod = build(p, 5'd29, (p == 0) ? 5'd30 : 5'(d), (p == 0) ? 5'(d) : 5'd0, ~imm);
              cons = build(c, (m != 1) ? 5'(d) : 5'd28, (m != 0) ? 5'(d) : 5'd27, 5'd26, imm);
              repeat (3) step(NOP);
              step(prod);
              for (int k = 1; k < gap; k++) step(NOP);
              step(cons);
              chk({tg, " stall"}, int'(cap_stall), int'(ld));
              if (cap_stall) begin
                step(cons);
                chk({tg, " R9 bubble"}, int'(cap_bub), 1);
                chk({tg, " R9 restall"}, int'(cap_stall), 0);
              end
              step(NOP);
              chk({tg, " sel_a"}, int'(cap_a), ea);
              chk({tgb, " sel_b"}, int'(cap_b), eb);
              chk({tg, " bubble"}, int'(cap_bub), 0);
            end
          end
        end
      end
    end

    // R6: two writers of register 5, nearer one wins
    repeat (3) step(NOP);
    step(build(0, 5'd1, 5'd2, 5'd5, 16'h0));
    step(build(1, 5'd3, 5'd5, 5'd0, 16'h1234));
    step(build(0, 5'd5, 5'd5, 5'd9, 16'h0));
    step(NOP);
    chk("R6 sel_a", int'(cap_a), 2);
    chk("R6 sel_b", int'(cap_b), 2);

    // R6: writers at distance 2 and 3, only distance 2 visible
    repeat (3) step(NOP);
    step(build(2, 5'd1, 5'd6, 5'd0, 16'hFFFC));
    step(build(1, 5'd3, 5'd6, 5'd0, 16'h0004));
    step(NOP);
    step(build(3, 5'd6, 5'd6, 5'd0, 16'h0008));
    step(NOP);
    chk("R6 far sel_a", int'(cap_a), 1);
    chk("R6 far sel_b", int'(cap_b), 1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule